// File: doc/BRIEF.md
# Free-Running Bus Timer with Coherent Byte Reads

This block is a 16-bit up-counter that runs without stopping. A fixed clock divider sits in front of it, so the counter moves once every four clocks by default. An 8-bit processor reads the count as two bytes through a small register bus. The bus has an address, a read strobe, a write strobe and a data byte in each direction. The design returns read data in the same cycle as the read strobe, and any side effects of a read take place at the following clock edge.

Software must be able to read the count one byte at a time without tearing the value. When the high byte is read, the low byte of the same instant is captured in a hold register, and later low-byte reads return that held value. The hold register is released by the next low-byte read. The block also sets a sticky overflow flag each time the counter wraps. When the matching enable bit is set, this flag raises an interrupt request. Software clears the flag by reading the status register and then the low byte.

Top module: `frc_timer`

## Requirements
- R1: After synchronous reset the counter holds 0xFFFC and the prescaler phase is zero. The control register, the status register and the `irq` output all read as zero.
- R2: The counter advances by exactly one every PRE_DIV clocks (default 4) and wraps from 0xFFFF to 0x0000.
- R3: When the counter wraps, the overflow flag is set. The flag is bit 5 of the status register at offset 0x13.
- R4: A read of the high byte (offset 0x18) captures the low byte of that same cycle. The next read of the low byte (offset 0x19) returns the captured value, and later low-byte reads return the live count again.
- R5: A low-byte read with no high-byte read since the last low-byte read returns the live low byte.
- R6: Reads of any register never change the count or the prescaler phase.
- R7: A status read that sees the flag set, followed later by a low-byte read, clears the flag.
- R8: A low-byte read that does not follow a status read which saw the flag set leaves the flag set.
- R9: If a counter wrap occurs in the same cycle as the clearing low-byte read, the flag stays set.
- R10: Bit 5 of the control register (offset 0x12) is the overflow interrupt enable. `irq` is high exactly while the flag and the enable are both set. All other control and status bits read as zero.
- R11: Writes to the counter high-byte and low-byte offsets, and writes to the status offset, have no effect.
- R12: Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Overflow interrupt request |

## Verification
The bench builds the block with PRE_DIV set to 2 and keeps the default reset preset of 0xFFFC. The first wrap therefore arrives within a few clocks of reset, and a second wrap comes about 131 thousand clocks later. That second wrap makes it possible to line up a clearing low-byte read with a wrap in the same cycle (R9) while the run still finishes within budget. The bench applies a second reset between phases, so that the clear sequence and the collision case each begin from a known flag state.

// File: rtl/frc_timer_pkg.sv
package frc_timer_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_STAT,
        SEL_CNTH,
        SEL_CNTL
    } reg_sel_e;

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [BYTE_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [BYTE_W-1:0] bit_mask(input int pos);
        return BYTE_W'(1) << pos;
    endfunction

endpackage

// File: rtl/frc_prescaler.sv
module frc_prescaler #(
    parameter int PRE_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);
    localparam bit IS_POW2 = ((1 << PW) == PRE_DIV);

    logic [PW-1:0] phase_q;

    generate
        if (IS_POW2) begin : g_pow2
            always_ff @(posedge clk) begin
                if (rst) phase_q <= '0;
                else     phase_q <= phase_q + 1'b1;
            end
            assign tick = &phase_q;
        end else begin : g_cmp
            always_ff @(posedge clk) begin
                if (rst)                  phase_q <= '0;
                else if (phase_q == LAST) phase_q <= '0;
                else                      phase_q <= phase_q + 1'b1;
            end
            assign tick = (phase_q == LAST);
        end
    endgenerate

endmodule

// File: rtl/frc_counter.sv
module frc_counter #(
    parameter int               CNT_W  = 16,
    parameter logic [CNT_W-1:0] PRESET = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= PRESET;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    assign cnt  = cnt_q;
    assign wrap = tick && (cnt_q == '1);

endmodule

// File: rtl/frc_lo_latch.sv
module frc_lo_latch #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] live,
    input  logic         capture,
    input  logic         release_i,
    output logic [W-1:0] view,
    output logic         frozen
);
    logic [W-1:0] hold_q;
    logic         frz_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            frz_q  <= 1'b0;
        end else if (capture) begin
            hold_q <= live;
            frz_q  <= 1'b1;
        end else if (release_i) begin
            frz_q  <= 1'b0;
        end
    end

    assign view   = frz_q ? hold_q : live;
    assign frozen = frz_q;

endmodule

// File: rtl/frc_flags.sv
module frc_flags
    import frc_timer_pkg::*;
#(
    parameter int IEN_BIT = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wrap,
    input  logic              stat_rd,
    input  logic              lo_rd,
    input  logic              ctrl_wr,
    input  logic [BYTE_W-1:0] ctrl_wdata,
    output logic [BYTE_W-1:0] ctrl,
    output logic              tof,
    output logic              arm,
    output logic              irq
);
    localparam logic [BYTE_W-1:0] IEN_MASK = bit_mask(IEN_BIT);

    logic [BYTE_W-1:0] ctrl_q;
    logic              tof_q;
    logic              arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            tof_q  <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= ctrl_wdata & IEN_MASK;
            if (stat_rd)    arm_q <= tof_q;
            else if (lo_rd) arm_q <= 1'b0;
            if (wrap)                tof_q <= 1'b1;
            else if (lo_rd && arm_q) tof_q <= 1'b0;
        end
    end

    assign ctrl = ctrl_q;
    assign tof  = tof_q;
    assign arm  = arm_q;
    assign irq  = tof_q && ctrl_q[IEN_BIT];

endmodule

// File: rtl/frc_timer.sv
module frc_timer
    import frc_timer_pkg::*;
#(
    parameter int                PRE_DIV     = 4,
    parameter logic [CNT_W-1:0]  RESET_VALUE = 16'hFFFC,
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] CTRL_OFS    = ADDR_W'('h12),
    parameter logic [ADDR_W-1:0] STAT_OFS    = ADDR_W'('h13),
    parameter logic [ADDR_W-1:0] CNTH_OFS    = ADDR_W'('h18),
    parameter logic [ADDR_W-1:0] CNTL_OFS    = ADDR_W'('h19),
    parameter int                IEN_BIT     = 5,
    parameter int                TOF_BIT     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [BYTE_W-1:0] TOF_MASK = bit_mask(TOF_BIT);

    bus_req_t          req;
    logic              tick;
    logic              wrap;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] lo_view;
    logic              lo_frozen;
    logic [BYTE_W-1:0] ctrl_q;
    logic              tof;
    logic              arm;
    logic              hi_rd, lo_rd, stat_rd, ctrl_rd, ctrl_wr;

    always_comb begin
        req.rd    = bus_rd;
        req.wr    = bus_wr;
        req.wdata = bus_wdata;
        if (bus_addr == CTRL_OFS)      req.sel = SEL_CTRL;
        else if (bus_addr == STAT_OFS) req.sel = SEL_STAT;
        else if (bus_addr == CNTH_OFS) req.sel = SEL_CNTH;
        else if (bus_addr == CNTL_OFS) req.sel = SEL_CNTL;
        else                           req.sel = SEL_NONE;
    end

    assign hi_rd   = req.rd && (req.sel == SEL_CNTH);
    assign lo_rd   = req.rd && (req.sel == SEL_CNTL);
    assign stat_rd = req.rd && (req.sel == SEL_STAT);
    assign ctrl_rd = req.rd && (req.sel == SEL_CTRL);
    assign ctrl_wr = req.wr && (req.sel == SEL_CTRL);

    frc_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    frc_counter #(.CNT_W(CNT_W), .PRESET(RESET_VALUE)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .cnt  (cnt_q),
        .wrap (wrap)
    );

    frc_lo_latch #(.W(BYTE_W)) u_lat (
        .clk       (clk),
        .rst       (rst),
        .live      (cnt_q[BYTE_W-1:0]),
        .capture   (hi_rd),
        .release_i (lo_rd),
        .view      (lo_view),
        .frozen    (lo_frozen)
    );

    frc_flags #(.IEN_BIT(IEN_BIT)) u_flg (
        .clk        (clk),
        .rst        (rst),
        .wrap       (wrap),
        .stat_rd    (stat_rd),
        .lo_rd      (lo_rd),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (req.wdata),
        .ctrl       (ctrl_q),
        .tof        (tof),
        .arm        (arm),
        .irq        (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (req.rd) begin
            case (req.sel)
                SEL_CTRL: bus_rdata = ctrl_q;
                SEL_STAT: bus_rdata = tof ? TOF_MASK : '0;
                SEL_CNTH: bus_rdata = cnt_q[CNT_W-1:BYTE_W];
                SEL_CNTL: bus_rdata = lo_view;
                default:  bus_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/frc_timer_chk.sv
module frc_timer_chk
    import frc_timer_pkg::*;
#(
    parameter int IEN_BIT = 5,
    parameter int TOF_BIT = 5
) (
    input logic              clk,
    input logic              rst,
    input logic [CNT_W-1:0]  cnt_q,
    input logic              wrap,
    input logic              tof,
    input logic              arm,
    input logic              irq,
    input logic [BYTE_W-1:0] ctrl_q,
    input logic              hi_rd,
    input logic              lo_rd,
    input logic              stat_rd,
    input logic              ctrl_rd,
    input logic              lo_frozen,
    input logic [BYTE_W-1:0] lo_view,
    input logic [BYTE_W-1:0] bus_rdata
);
    localparam logic [BYTE_W-1:0] IEN_MASK = bit_mask(IEN_BIT);
    localparam logic [BYTE_W-1:0] TOF_MASK = bit_mask(TOF_BIT);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |-> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt_q) |=> $stable(cnt_q)); // R2
    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        wrap |=> tof); // R3
    AST_HIGH_CAPTURES: assert property (@(posedge clk) disable iff (rst)
        hi_rd |=> (lo_frozen && lo_view == $past(cnt_q[BYTE_W-1:0]))); // R4
    AST_LIVE_LOW: assert property (@(posedge clk) disable iff (rst)
        (lo_rd && !lo_frozen) |-> bus_rdata == cnt_q[BYTE_W-1:0]); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (tof && arm && lo_rd && !wrap) |=> !tof); // R7
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
        (tof && !(arm && lo_rd)) |=> tof); // R8
    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[IEN_BIT] |-> !irq); // R10
    AST_CTRL_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        ctrl_rd |-> (bus_rdata & ~IEN_MASK) == '0); // R10
    AST_STAT_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        stat_rd |-> (bus_rdata & ~TOF_MASK) == '0); // R10

endmodule

bind frc_timer frc_timer_chk #(.IEN_BIT(IEN_BIT), .TOF_BIT(TOF_BIT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_q     (cnt_q),
    .wrap      (wrap),
    .tof       (tof),
    .arm       (arm),
    .irq       (irq),
    .ctrl_q    (ctrl_q),
    .hi_rd     (hi_rd),
    .lo_rd     (lo_rd),
    .stat_rd   (stat_rd),
    .ctrl_rd   (ctrl_rd),
    .lo_frozen (lo_frozen),
    .lo_view   (lo_view),
    .bus_rdata (bus_rdata)
);

// File: tb/frc_timer_bench.sv
`timescale 1ns/1ps
module frc_timer_bench;

    localparam int BPRE = 2;
    localparam logic [7:0] A_CTRL = 8'h12;
    localparam logic [7:0] A_STAT = 8'h13;
    localparam logic [7:0] A_CNTH = 8'h18;
    localparam logic [7:0] A_CNTL = 8'h19;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] addr = 8'h00;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int m_cnt = 0, m_pre = 0, m_lat = 0;
    bit m_frz = 0, m_tof = 0, m_arm = 0, m_ien = 0;
    bit t_tick, t_wrap, o_tof, o_arm;
    int o_cnt;

    always #2 clk = ~clk;

    frc_timer #(.PRE_DIV(BPRE)) u_frc_timer (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (addr),
        .bus_rd    (rd),
        .bus_wr    (wr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .irq       (irq)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 16'hFFFC; m_pre = 0; m_lat = 0;
            m_frz = 0; m_tof = 0; m_arm = 0; m_ien = 0;
        end else begin
            t_tick = (m_pre == BPRE - 1);
            t_wrap = t_tick && (m_cnt == 16'hFFFF);
            o_tof = m_tof; o_arm = m_arm; o_cnt = m_cnt;
            m_pre = t_tick ? 0 : m_pre + 1;
            if (t_tick) m_cnt = (m_cnt + 1) % 65536;
            if (rd && addr == A_CNTH) begin m_lat = o_cnt % 256; m_frz = 1; end
            if (rd && addr == A_CNTL) begin
                m_frz = 0; m_arm = 0;
                if (o_arm) m_tof = 0;
            end
            if (rd && addr == A_STAT) m_arm = o_tof;
            if (wr && addr == A_CTRL) m_ien = wdata[5];
            if (t_wrap) m_tof = 1;
        end
    end

    function automatic int model_rdata(input logic [7:0] a);
        if (a == A_CTRL) return m_ien ? 8'h20 : 8'h00;
        if (a == A_STAT) return m_tof ? 8'h20 : 8'h00;
        if (a == A_CNTH) return m_cnt / 256;
        if (a == A_CNTL) return m_frz ? m_lat : m_cnt % 256;
        return 0;
    endfunction

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // irq compared against the model on every clock (R10)
    always @(negedge clk) begin
        if (!rst && !done) check("R10 irq", int'(irq), int'(m_tof && m_ien));
    end

    task automatic do_read(input logic [7:0] a, input string req);
        addr = a; rd = 1'b1;
        #1;
        check(req, int'(rdata), model_rdata(a));
        @(negedge clk);
        rd = 1'b0; addr = 8'h00;
    endtask

    task automatic do_write(input logic [7:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0; addr = 8'h00; wdata = 8'h00;
    endtask

    task automatic apply_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        apply_reset();
        // R1: reset state, checked against fixed values as well
        addr = A_CNTH; rd = 1'b1; #1;
        check("R1 count high", int'(rdata), 8'hFF);
        @(negedge clk); rd = 1'b0;
        do_read(A_CNTL, "R4 held low after reset");
        do_read(A_CTRL, "R1 ctrl");
        do_read(A_STAT, "R1 status");
        check("R1 irq", int'(irq), 0);
        // R2/R3: first wrap arrives early
        repeat (12) @(negedge clk);
        do_read(A_CNTH, "R2 count high after wrap");
        do_read(A_CNTL, "R2 count low after wrap");
        // R8: low read without arming keeps flag
        do_read(A_CNTL, "R8 plain low read");
        do_read(A_STAT, "R3 flag set");
        check("R3 flag bit fixed", int'(rdata), 8'h20);
        do_read(A_CNTH, "R7 high read between");
        do_read(A_CNTL, "R7 clearing low read");
        do_read(A_STAT, "R7 flag cleared");
        // R4: capture, hold across idle cycles, then transparent
        do_read(A_CNTH, "R4 high");
        repeat (9) @(negedge clk);
        do_read(A_CNTL, "R4 frozen low");
        repeat (3) @(negedge clk);
        do_read(A_CNTL, "R4 transparent again");
        // R5: lone low reads
        do_read(A_CNTL, "R5 live low");
        @(negedge clk);
        do_read(A_CNTL, "R5 live low later");
        // R6: burst of reads does not disturb the count
        for (int i = 0; i < 6; i++) begin
            do_read(A_CNTH, "R6 burst high");
            do_read(A_STAT, "R6 burst status");
            do_read(A_CNTL, "R6 burst low");
        end
        // R10: control register keeps only the enable bit
        do_write(A_CTRL, 8'hFF);
        do_read(A_CTRL, "R10 ctrl readback");
        do_write(A_CTRL, 8'h00);
        do_read(A_CTRL, "R10 ctrl cleared");
        // R11: counter and status writes ignored
        do_write(A_CNTH, 8'h12);
        do_write(A_CNTL, 8'h34);
        do_write(A_STAT, 8'hFF);
        do_read(A_CNTH, "R11 high after write");
        do_read(A_CNTL, "R11 low after write");
        do_read(A_STAT, "R11 status after write");
        // R12: unmapped offsets
        do_read(8'h00, "R12 unmapped 00");
        do_read(8'h15, "R12 unmapped 15");
        do_read(8'hFF, "R12 unmapped FF");

        // phase B: flag set, armed, clear collides with the next wrap
        apply_reset();
        repeat (12) @(negedge clk);
        do_write(A_CTRL, 8'h20);
        check("R10 irq raised", int'(irq), 1);
        do_read(A_STAT, "R9 arming status read");
        while (!(m_cnt == 16'hFFFF && m_pre == BPRE - 1)) @(negedge clk);
        do_read(A_CNTL, "R9 colliding low read");
        do_read(A_STAT, "R9 flag kept");
        check("R9 irq kept", int'(irq), 1);
        do_read(A_STAT, "R7 re-arm");
        do_read(A_CNTL, "R7 clear after collision");
        do_read(A_STAT, "R7 flag now clear");
        check("R10 irq dropped", int'(irq), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule